// File: doc/BRIEF.md
# Serial Bus Pause Controller

This block sits between the pins of a serial slave port and the slave's bit engine. It oversamples chip select, serial clock, serial data in and an active-low pause pin with a faster system clock. It converts the serial clock into one-cycle pulses for the engine: `eng_shift` for each capture edge, carrying the sampled data bit, and `eng_adv` for each launch edge. When the pause pin is asserted during a selection, the pulses stop. The engine keeps its bit position, and the transfer later resumes at the same bit. The output-enable for the data-out driver follows the pause pin directly, whatever the serial clock is doing.

The engine-side pause obeys a clock-phase rule. A change on the pause pin while the serial clock is low takes effect at once. A change while the clock is high is held back until the next falling clock edge. The control is a five-state machine. `ST_IDLE` means deselected. `ST_RUN` forwards edges. `ST_PEND_PAUSE` means the pause was requested with the clock high, and edges are still forwarded. `ST_PAUSED` blocks all edges. `ST_PEND_RESUME` means the pause was released with the clock high, and edges are still blocked.

The transitions are as follows:
- *select*: IDLE→RUN when CS goes low.
- *pause-now*: RUN→PAUSED when the pause pin goes low with the clock low.
- *pause-defer*: RUN→PEND_PAUSE when the pause pin goes low with the clock high.
- *pause-land*: PEND_PAUSE→PAUSED on a falling clock edge.
- *pause-cancel*: PEND_PAUSE→RUN when the pause pin goes high again before that falling edge.
- *resume-now*: PAUSED→RUN when the pause pin goes high with the clock low.
- *resume-defer*: PAUSED→PEND_RESUME when the pause pin goes high with the clock high.
- *resume-land*: PEND_RESUME→RUN on a falling clock edge.
- *resume-cancel*: PEND_RESUME→PAUSED when the pause pin goes low again.
- *deselect*: any state→IDLE when CS goes high.

Top module: `spi_hold_gate`

## Requirements
- R1: While CS is high, no `eng_shift` or `eng_adv` pulse is produced, and `eng_sel` and `so_oe` are 0, whatever SCK and SI do.
- R2: While selected and not paused, each SCK rising edge gives exactly one `eng_shift` pulse with `eng_bit` equal to SI at that edge. Each SCK falling edge gives exactly one `eng_adv` pulse.
- R3: If the pause pin falls while SCK is low, no further edge is forwarded from then on.
- R4: If the pause pin falls while SCK is high, the next SCK falling edge is still forwarded as `eng_adv`, and nothing after it is forwarded.
- R5: If the pause pin rises while SCK is low, the very next SCK rising edge is forwarded.
- R6: If the pause pin rises while SCK is high, the falling edge that ends that high phase is not forwarded. The rising edge after it is forwarded.
- R7: SCK and SI activity during a pause is ignored. A byte interrupted by a pause at any bit position arrives complete and in order, MSB first.
- R8: `so_oe` goes to 0 within three system clocks of the pause pin falling and returns to 1 within three system clocks of it rising, independent of SCK.
- R9: A rise of CS during a pause clears the pause. The next selection with the pause pin high forwards its first SCK edge.
- R10: A pause request made with SCK high and withdrawn before SCK falls does not pause the transfer.
- R11: After reset, `eng_sel`, `eng_shift`, `eng_adv` and `so_oe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_pin | input | 1 | Chip select pin, active low |
| sck_pin | input | 1 | Serial clock pin |
| si_pin | input | 1 | Serial data in pin |
| hold_n_pin | input | 1 | Pause pin, active low |
| eng_sel | output | 1 | Engine selected (CS low as seen after sync) |
| eng_shift | output | 1 | One-cycle pulse per forwarded SCK rising edge |
| eng_bit | output | 1 | SI bit captured with the latest `eng_shift` |
| eng_adv | output | 1 | One-cycle pulse per forwarded SCK falling edge |
| so_oe | output | 1 | Enable for the data-out driver |

## Verification
The assertions assume that every pin holds each level for several system clocks, so that the synchronizer never misses an SCK phase. They also assume that SI is stable around each SCK rising edge, because SI shares the synchronizer depth of SCK. The stimulus moves only one pin at a time and then waits seven system clocks before the next change, so no two pin changes land in the same sampled cycle. The sweep covers every bit position of a byte, with both clock phases at pause entry and both at release. It checks the forwarded-edge counts after every pin move.

// File: rtl/hold_pause_pkg.sv
package hold_pause_pkg;

    // Pause control states; see the brief for the transition names.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_PEND_PAUSE,
        ST_PAUSED,
        ST_PEND_RESUME
    } hp_state_e;

    // Bit positions of the pins inside the shared synchronizer vector.
    localparam int unsigned PIN_CS   = 0;
    localparam int unsigned PIN_HOLD = 1;
    localparam int unsigned PIN_SCK  = 2;
    localparam int unsigned PIN_SI   = 3;
    localparam int unsigned PIN_NUM  = 4;

endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
    parameter int unsigned WIDTH   = 4,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // One flop chain per bit, each bit with its own reset level.
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[b]}};
            end else begin
                chain <= {chain[STAGES-2:0], d[b]};
            end
        end
        assign q[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/hp_edge.sv
module hp_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= RST_VAL;
        end else begin
            prev_q <= lvl;
        end
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

endmodule

// File: rtl/hp_fsm.sv
module hp_fsm
    import hold_pause_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_s,
    input  logic hold_s,
    input  logic sck_s,
    input  logic sck_rise,
    input  logic sck_fall,
    input  logic si_s,
    output logic shift_en,
    output logic shift_bit,
    output logic adv_en,
    output logic sel,
    output logic so_oe
);
    hp_state_e state_q, state_d;
    logic      live;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!cs_s) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (cs_s)         state_d = ST_IDLE;
                else if (!hold_s) state_d = sck_s ? ST_PEND_PAUSE : ST_PAUSED;
            end
            ST_PEND_PAUSE: begin
                if (cs_s)          state_d = ST_IDLE;
                else if (hold_s)   state_d = ST_RUN;
                else if (sck_fall) state_d = ST_PAUSED;
            end
            ST_PAUSED: begin
                if (cs_s)        state_d = ST_IDLE;
                else if (hold_s) state_d = sck_s ? ST_PEND_RESUME : ST_RUN;
            end
            ST_PEND_RESUME: begin
                if (cs_s)          state_d = ST_IDLE;
                else if (!hold_s)  state_d = ST_PAUSED;
                else if (sck_fall) state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Edges pass only in the two forwarding states.
    assign live = !cs_s && (state_q == ST_RUN || state_q == ST_PEND_PAUSE);

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_en  <= 1'b0;
            shift_bit <= 1'b0;
            adv_en    <= 1'b0;
            sel       <= 1'b0;
            so_oe     <= 1'b0;
        end else begin
            shift_en <= sck_rise && live;
            adv_en   <= sck_fall && live;
            if (sck_rise && live) shift_bit <= si_s;
            sel      <= !cs_s && (state_q != ST_IDLE);
            so_oe    <= !cs_s && hold_s;
        end
    end

    // R9: deselection always returns to idle, dropping any pause.
    a_r9_cs_clears_pause: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (state_q == ST_IDLE));

    // R3: a settled pause lets no edge through.
    a_r3_paused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAUSED) |=> (!shift_en && !adv_en));

    // R4: a deferred pause forwards its landing fall, then pauses.
    a_r4_deferred_pause_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND_PAUSE && sck_fall && !cs_s && !hold_s)
        |=> (state_q == ST_PAUSED && adv_en));

    // R6: a deferred resume swallows its landing fall.
    a_r6_deferred_resume_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND_RESUME && sck_fall && !cs_s && hold_s)
        |=> (state_q == ST_RUN && !adv_en));

endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate
    import hold_pause_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_pin,
    input  logic sck_pin,
    input  logic si_pin,
    input  logic hold_n_pin,
    output logic eng_sel,
    output logic eng_shift,
    output logic eng_bit,
    output logic eng_adv,
    output logic so_oe
);
    // Idle pin levels: deselected, not paused, clock low.
    localparam logic [PIN_NUM-1:0] PIN_IDLE =
        (PIN_NUM'(1) << PIN_CS) | (PIN_NUM'(1) << PIN_HOLD);

    logic [PIN_NUM-1:0] pins_raw, pins_s;
    logic cs_s, hold_s, sck_s, si_s, sck_rise, sck_fall;

    always_comb begin
        pins_raw           = '0;
        pins_raw[PIN_CS]   = cs_n_pin;
        pins_raw[PIN_HOLD] = hold_n_pin;
        pins_raw[PIN_SCK]  = sck_pin;
        pins_raw[PIN_SI]   = si_pin;
    end

    hp_sync #(.WIDTH(PIN_NUM), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
    );

    assign cs_s   = pins_s[PIN_CS];
    assign hold_s = pins_s[PIN_HOLD];
    assign sck_s  = pins_s[PIN_SCK];
    assign si_s   = pins_s[PIN_SI];

    hp_edge #(.RST_VAL(1'b0)) u_sck_edge (
        .clk(clk), .rst_n(rst_n), .lvl(sck_s), .rise(sck_rise), .fall(sck_fall)
    );

    hp_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .hold_s(hold_s), .sck_s(sck_s),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s),
        .shift_en(eng_shift), .shift_bit(eng_bit), .adv_en(eng_adv),
        .sel(eng_sel), .so_oe(so_oe)
    );

    // R8: the driver enable drops one cycle after a sampled pause.
    a_r8_oe_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_s |=> !so_oe);

    // R1: nothing reaches the engine while deselected.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (!eng_shift && !eng_adv && !eng_sel));

    // R2: a rise and a fall are never forwarded together.
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eng_shift, eng_adv}));

endmodule

// File: tb/tb_spi_hold_gate.sv
module tb_spi_hold_gate;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n_pin = 1'b1, sck_pin = 1'b0, si_pin = 1'b0, hold_n_pin = 1'b1;
    logic eng_sel, eng_shift, eng_bit, eng_adv, so_oe;

    always #4 clk = ~clk;

    spi_hold_gate dut (
        .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n_pin), .sck_pin(sck_pin),
        .si_pin(si_pin), .hold_n_pin(hold_n_pin), .eng_sel(eng_sel),
        .eng_shift(eng_shift), .eng_bit(eng_bit), .eng_adv(eng_adv), .so_oe(so_oe)
    );

    int rise_cnt = 0, fall_cnt = 0, exp_rise = 0, exp_fall = 0;
    int n_chk = 0, n_fail = 0;
    logic [7:0] rx = '0;
    bit done = 0;

    always @(negedge clk) begin
        if (eng_shift) begin
            rise_cnt <= rise_cnt + 1;
            rx <= {rx[6:0], eng_bit};
        end
        if (eng_adv) fall_cnt <= fall_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (7) @(posedge clk);
        #1;
    endtask

    task automatic chk_counts(input string req);
        chk(rise_cnt == exp_rise, {req, " rises"}, rise_cnt, exp_rise);
        chk(fall_cnt == exp_fall, {req, " falls"}, fall_cnt, exp_fall);
    endtask

    task automatic clk_bit(input string req);
        sck_pin = 1'b1; settle(); exp_rise++; chk_counts(req);
        sck_pin = 1'b0; settle(); exp_fall++; chk_counts(req);
    endtask

    // One byte with a pause inserted before bit k.
    // pa: pause pin falls with SCK high; rb: pause pin rises with SCK high.
    task automatic xfer(input logic [7:0] d, input int k, input bit pa, input bit rb);
        cs_n_pin = 1'b0; settle();
        chk(eng_sel == 1'b1, "R2 selected", eng_sel, 1);
        for (int i = 0; i < 8; i++) begin
            si_pin = d[7-i];
            if (i == k) begin
                if (!pa) begin
                    hold_n_pin = 1'b0; settle();
                    chk(so_oe == 1'b0, "R8 oe off", so_oe, 0);
                    sck_pin = 1'b1; si_pin = ~si_pin; settle();
                    sck_pin = 1'b0; settle();
                    chk_counts("R3");
                end else begin
                    sck_pin = 1'b1; settle(); exp_rise++;
                    hold_n_pin = 1'b0; settle();
                    chk(so_oe == 1'b0, "R8 oe off", so_oe, 0);
                    chk_counts("R4 before fall");
                    si_pin = ~si_pin;
                    sck_pin = 1'b0; settle(); exp_fall++;
                    chk_counts("R4 landing fall");
                    sck_pin = 1'b1; settle();
                    sck_pin = 1'b0; settle();
                    chk_counts("R7 ignored edges");
                end
                si_pin = d[7-i];
                if (!rb) begin
                    hold_n_pin = 1'b1; settle();
                    chk(so_oe == 1'b1, "R8 oe on", so_oe, 1);
                end else begin
                    sck_pin = 1'b1; settle();
                    hold_n_pin = 1'b1; settle();
                    chk(so_oe == 1'b1, "R8 oe on", so_oe, 1);
                    chk_counts("R6 high phase");
                    sck_pin = 1'b0; settle();
                    chk_counts("R6 swallowed fall");
                end
                if (!pa) clk_bit(rb ? "R6 next rise" : "R5 next rise");
            end else begin
                clk_bit("R2");
            end
        end
        chk(rx == d, "R7 byte", rx, d);
        cs_n_pin = 1'b1; settle();
        chk(eng_sel == 1'b0, "R1 deselect", eng_sel, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        chk(eng_sel == 0 && eng_shift == 0 && eng_adv == 0 && so_oe == 0,
            "R11 reset", {eng_sel, eng_shift, eng_adv, so_oe}, 0);
        rst_n = 1'b1; settle();

        // R1: clocking while deselected
        for (int i = 0; i < 4; i++) begin
            si_pin = i[0]; sck_pin = 1'b1; settle(); sck_pin = 1'b0; settle();
        end
        chk_counts("R1");
        chk(eng_sel == 0 && so_oe == 0, "R1 outputs", {eng_sel, so_oe}, 0);

        // Sweep: every bit position, both entry and release phases.
        for (int k = 0; k < 8; k++) begin
            for (int m = 0; m < 4; m++) begin
                xfer(8'(8'hA5 ^ (k * 37 + m * 91)), k, m[0], m[1]);
            end
        end

        // R10: withdrawn pause request
        cs_n_pin = 1'b0; settle();
        sck_pin = 1'b1; si_pin = 1'b1; settle(); exp_rise++;
        hold_n_pin = 1'b0; settle();
        hold_n_pin = 1'b1; settle();
        sck_pin = 1'b0; settle(); exp_fall++;
        chk_counts("R10 fall kept");
        clk_bit("R10 still running");

        // R9: deselect during pause clears it
        hold_n_pin = 1'b0; settle();
        cs_n_pin = 1'b1; settle();
        hold_n_pin = 1'b1; settle();
        cs_n_pin = 1'b0; settle();
        clk_bit("R9 fresh selection");
        cs_n_pin = 1'b1; settle();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule